// File: doc/BRIEF.md
# Write-Started Fixed-Frame Serial Transmitter

This block sends one asynchronous serial character each time the host writes a byte to it. There is nothing to configure. The frame is always a low start bit, then the data bits with the least significant bit first, then a high stop level. The line stays high at that level for as long as nothing else is written.

A free-running divider turns the system clock into one tick per bit time. Every write clears this divider, so bit boundaries line up with the write. The written byte waits in a holding register while the start bit is on the line. It then moves to a shift register that drives the registered serial output.

A busy flag covers the whole frame, up to the end of the first stop bit. A one-clock completion pulse follows, which can be used as an interrupt request. Software is expected to wait for that pulse before it writes again. If it writes early anyway, the frame in progress is abandoned and the new byte starts from a fresh start bit.

Top module: `wr_serial_tx`

## Requirements
- R1: While reset is held, and afterwards until the first write, the serial output is high, busy is low and the completion pulse is low.
- R2: A write needs no earlier setup. In the clock after the write edge the serial output is low (the start bit) and busy is high.
- R3: Each bit lasts exactly CLKS_PER_BIT clocks, counted from the write edge. The serial output changes only on those boundaries.
- R4: Data bit i of the written byte is on the line during bit period i+1 after the write, where period 0 is the start bit. The least significant bit goes first.
- R5: From bit period DATA_BITS+1 onward the output is high, and it stays high with no time limit until the next write.
- R6: Busy stays high for (DATA_BITS+2)·CLKS_PER_BIT clocks after the write edge and then falls. On that same edge the completion output rises for exactly one clock.
- R7: A change on the data input while no write is strobed has no effect on the frame being sent.
- R8: A write while busy is high abandons the current frame. No completion pulse is given for the abandoned frame, and the new byte is sent starting from a start bit aligned to the new write.
- R9: A write on the very edge where a frame would end suppresses that frame's completion pulse. It starts the new frame with busy staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-clock write strobe that starts a frame |
| wr_data | input | DATA_BITS | Byte to send, sampled when wr_en is high |
| txd | output | 1 | Registered serial line, high when idle |
| busy | output | 1 | High from the write until the end of the first stop bit |
| done | output | 1 | One-clock pulse when a frame completes |

## Verification
The bench builds the block with 16 clocks per bit and 8 data bits. With a bit time this short, about forty frames fit easily inside the run. Writes land at every offset inside a frame, including back-to-back strobes and a strobe on the exact closing edge. The data input is scrambled between writes, so holding-register leaks show up on the line. The divider-of-one variant is selected by generate and is not built by this bench.

// File: rtl/wst_pkg.sv
package wst_pkg;
   localparam logic LINE_IDLE  = 1'b1;
   localparam logic LINE_START = 1'b0;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_START = 2'd1,
      PH_DATA  = 2'd2,
      PH_STOP  = 2'd3
   } wst_phase_e;
endpackage

// File: rtl/wst_bit_timer.sv
module wst_bit_timer #(
   parameter int CLKS_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

   generate
      if (CLKS_PER_BIT == 1) begin : g_every_clock
         assign tick = 1'b1;
      end else begin : g_counter
         localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (restart || cnt_q == LAST)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wst_frame_seq.sv
module wst_frame_seq
   import wst_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic busy,
   output logic adv_first,
   output logic adv_data,
   output logic adv_last,
   output logic frame_end
);
   localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

   wst_phase_e    phase_q;
   logic [IW-1:0] idx_q;
   logic          step;

   assign step = tick && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
      end else if (start) begin
         phase_q <= PH_START;
         idx_q   <= '0;
      end else if (tick) begin
         case (phase_q)
            PH_START: begin
               phase_q <= PH_DATA;
               idx_q   <= '0;
            end
            PH_DATA: begin
               if (idx_q == LAST_IDX)
                  phase_q <= PH_STOP;
               else
                  idx_q <= idx_q + 1'b1;
            end
            PH_STOP: phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (phase_q != PH_IDLE);
      adv_first = step && (phase_q == PH_START);
      adv_data  = step && (phase_q == PH_DATA) && (idx_q != LAST_IDX);
      adv_last  = step && (phase_q == PH_DATA) && (idx_q == LAST_IDX);
      frame_end = step && (phase_q == PH_STOP);
   end
endmodule

// File: rtl/wst_shift_out.sv
module wst_shift_out
   import wst_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] load_data,
   input  logic                 adv_first,
   input  logic                 adv_data,
   input  logic                 adv_last,
   output logic                 line
);
   logic [DATA_BITS-1:0] hold_q;
   logic [DATA_BITS-1:0] sh_q;
   logic                 line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         sh_q   <= '0;
         line_q <= LINE_IDLE;
      end else if (load) begin
         hold_q <= load_data;
         line_q <= LINE_START;
      end else if (adv_first) begin
         line_q <= hold_q[0];
         sh_q   <= hold_q >> 1;
      end else if (adv_data) begin
         line_q <= sh_q[0];
         sh_q   <= sh_q >> 1;
      end else if (adv_last) begin
         line_q <= LINE_IDLE;
      end
   end

   assign line = line_q;
endmodule

// File: rtl/wr_serial_tx.sv
module wr_serial_tx #(
   parameter int CLKS_PER_BIT = 16,
   parameter int DATA_BITS    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [DATA_BITS-1:0] wr_data,
   output logic                 txd,
   output logic                 busy,
   output logic                 done
);
   generate
      if (CLKS_PER_BIT < 1) begin : g_bad_div
         $error("wr_serial_tx: CLKS_PER_BIT must be at least 1");
      end
      if (DATA_BITS < 1 || DATA_BITS > 16) begin : g_bad_width
         $error("wr_serial_tx: DATA_BITS must be in 1..16");
      end
   endgenerate

   logic tick, adv_first, adv_data, adv_last, frame_end, done_q;

   wst_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) timer_i (
      .clk(clk), .rst_n(rst_n), .restart(wr_en), .tick(tick)
   );

   wst_frame_seq #(.DATA_BITS(DATA_BITS)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(wr_en), .tick(tick),
      .busy(busy), .adv_first(adv_first), .adv_data(adv_data),
      .adv_last(adv_last), .frame_end(frame_end)
   );

   wst_shift_out #(.DATA_BITS(DATA_BITS)) shift_i (
      .clk(clk), .rst_n(rst_n), .load(wr_en), .load_data(wr_data),
      .adv_first(adv_first), .adv_data(adv_data), .adv_last(adv_last),
      .line(txd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= frame_end;
   end

   assign done = done_q;
endmodule

// File: rtl/wr_serial_tx_chk.sv
module wr_serial_tx_chk #(
   parameter int CLKS_PER_BIT = 16
) (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic txd,
   input logic busy,
   input logic done
);
   localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

   logic [CW-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot_q <= '0;
      else if (wr_en || slot_q == LAST)    slot_q <= '0;
      else                                 slot_q <= slot_q + 1'b1;
   end

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);                                   // R5
   AST_WRITE_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (busy && !txd));                         // R2
   AST_BIT_EDGES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q != '0) |-> $stable(txd));                  // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                   // R6
   AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(busy));                             // R6
   AST_WRITE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !done);                                  // R9
endmodule

bind wr_serial_tx wr_serial_tx_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .txd(txd), .busy(busy), .done(done)
);

// File: tb/wr_serial_tx_tb.sv
`timescale 1ns/1ps
module wr_serial_tx_tb_top;
   localparam int N  = 16;
   localparam int DB = 8;
   localparam int FRAME = (DB + 2) * N;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DB-1:0] wr_data = '0;
   logic          txd, busy, done;

   int n_checks = 0;
   int n_bad    = 0;
   bit finished = 1'b0;

   int            edge_n = 0;
   bit            have_w = 1'b0;
   int            w_edge = 0;
   logic [DB-1:0] w_byte = '0;
   string         scen = "R1";

   always #4 clk = ~clk;

   wr_serial_tx #(.CLKS_PER_BIT(N), .DATA_BITS(DB)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .txd(txd), .busy(busy), .done(done)
   );

   task automatic check(string tag, string what, logic got, logic exp);
      n_checks++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] %s: actual=%0b expected=%0b at edge %0d",
                  tag, scen, what, got, exp, edge_n - 1);
      end
   endtask

   function automatic logic exp_line(int t, logic [DB-1:0] b);
      int p;
      p = t / N;
      if (p == 0)       return 1'b0;
      else if (p <= DB) return b[p-1];
      else              return 1'b1;
   endfunction

   // reference model: record each write edge
   always @(posedge clk) begin
      if (rst_n && wr_en) begin
         have_w <= 1'b1;
         w_edge <= edge_n;
         w_byte <= wr_data;
      end
      edge_n <= edge_n + 1;
   end

   // compare outputs away from the active edge
   always @(posedge clk) begin
      #2;
      if (!rst_n) begin
         check("R1", "txd in reset", txd, 1'b1);
         check("R1", "busy in reset", busy, 1'b0);
         check("R1", "done in reset", done, 1'b0);
      end else if (!have_w) begin
         check("R1", "txd before first write", txd, 1'b1);
         check("R1", "busy before first write", busy, 1'b0);
         check("R1", "done before first write", done, 1'b0);
      end else begin
         int t;
         int p;
         t = (edge_n - 1) - w_edge;
         p = t / N;
         if (p == 0)       check("R2", "start bit", txd, exp_line(t, w_byte));
         else if (p <= DB) check("R4", "data bit (R3 timing)", txd, exp_line(t, w_byte));
         else              check("R5", "stop/idle", txd, 1'b1);
         check("R6", "busy", busy, (t < FRAME));
         check("R6", "done", done, (t == FRAME));
      end
   end

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         wr_data = DB'($urandom);
      end
   endtask

   task automatic do_write(logic [DB-1:0] b);
      wr_en   = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = DB'($urandom);
   endtask

   initial begin
      void'($urandom(32'h5A17C0DE));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(30);                              // R1 idle after reset

      scen = "R2"; do_write(8'hA5); idle(FRAME + 5);
      scen = "R4"; do_write(8'h00); idle(FRAME + 3);
      scen = "R4"; do_write(8'hFF); idle(FRAME + 3);
      scen = "R5"; do_write(8'h01); idle(3 * FRAME);
      scen = "R7"; do_write(8'h3C); idle(FRAME + 2);  // data scrambled meanwhile
      scen = "R8"; do_write(8'h81); idle(5);
      do_write(8'h7E); idle(0);
      do_write(8'h55); idle(FRAME - 2);
      do_write(8'hC3); idle(FRAME + 4);
      scen = "R9"; do_write(8'h96); idle(FRAME - 1);
      do_write(8'h69); idle(FRAME + 4);

      for (int i = 0; i < 40; i++) begin
         int gap;
         if ($urandom % 4 == 0) begin
            scen = "R8";
            gap = int'($urandom % (FRAME - 1));
         end else begin
            scen = "R4";
            gap = FRAME - 1 + int'($urandom % 24);
         end
         do_write(DB'($urandom));
         idle(gap);
      end
      idle(FRAME + 8);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end
endmodule